// File: doc/BRIEF.md
# DTMF Steering and Guard-Time Controller

This block sits behind a tone-pair decoder. It takes the decoder's "two valid tones present" flag and its 4-bit digit code. It decides when a digit has really been keyed, and it holds that digit for the host. Two digital counters replace the resistor-capacitor timing network used in analog receivers. The first counter requires the tone to stay present without a break for a programmable number of clock cycles before the code is accepted. The second counter requires the tone to stay absent without a break for a separate programmable number of cycles before the digit is considered finished.

When the tone has been present long enough, the code is captured in an output latch and the guard output rises. The guard output then follows the presence flag for as long as the digit lasts. A few cycles after the capture, the delayed-steering flag rises to tell the host that a digit is ready. Short bursts are rejected, and short dropouts inside a digit are ignored. The data bus is modelled as a value plus a drive-enable signal, and it is only driven while the output enable is high.

Top module: `dtmf_steer`

## Requirements
- R1: After reset, guard_out and steer_dly are low and the output latch holds 0000.
- R2: When sig_det has been sampled high on ON_CYCLES consecutive rising clock edges, starting from idle, the latch loads code_in on that same edge and guard_out goes high.
- R3: A burst of sig_det that is high for fewer than ON_CYCLES consecutive edges leaves the latch unchanged, leaves guard_out low, and restarts the count.
- R4: Once a digit is registered, guard_out equals the sig_det value sampled on the previous edge. guard_out is low whenever the controller is idle or validating a tone.
- R5: steer_dly rises exactly SETTLE_CYCLES edges after the edge that loads the latch.
- R6: steer_dly falls on the edge at which sig_det has been sampled low on OFF_CYCLES consecutive edges. A low stretch shorter than OFF_CYCLES leaves steer_dly high and does not end the digit.
- R7: While a digit is registered, including during a dropout, changes on code_in do not alter the latch. A new code can only be registered after steer_dly has cleared.
- R8: With oe low, q_drive is 0 and q_data is 0 (bus released). With oe high, q_drive is 1 and q_data shows the latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sig_det | input | 1 | Decoder flag: a valid tone pair is present |
| code_in | input | CODE_W | Digit code from the decoder |
| oe | input | 1 | Output enable for the data bus |
| q_data | output | CODE_W | Latched code while enabled, 0 otherwise |
| q_drive | output | 1 | High while the bus is driven, low when it is high impedance |
| guard_out | output | 1 | Guard-time output; high from registration for as long as the tone lasts |
| steer_dly | output | 1 | Delayed steering flag: a digit is registered |

## Verification
A wrong count in the tone-present counter shows up as the latch and guard_out changing one edge early or late, at the first edge where the sweep samples them. A wrong count in the pause counter shows up as steer_dly falling off its exact edge, or falling during a tolerated dropout. A state that fails to return to idle shows up within one digit, because the following digit is then never captured on the bus. A latch that is not protected while a digit is held shows up on q_data as soon as code_in changes during the digit.

// File: rtl/dtmf_steer.sv
module dtmf_steer #(
  parameter int CODE_W        = 4,
  parameter int ON_CYCLES     = 40000,
  parameter int OFF_CYCLES    = 40000,
  parameter int SETTLE_CYCLES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sig_det,
  input  logic [CODE_W-1:0] code_in,
  input  logic              oe,
  output logic [CODE_W-1:0] q_data,
  output logic              q_drive,
  output logic              guard_out,
  output logic              steer_dly
);
  localparam int MAXC = (ON_CYCLES > OFF_CYCLES) ? ON_CYCLES : OFF_CYCLES;
  localparam int CW   = $clog2(MAXC + 1);
  localparam int SW   = $clog2(SETTLE_CYCLES + 1);
  localparam logic [CW-1:0] ON_LAST  = CW'(ON_CYCLES - 1);
  localparam logic [CW-1:0] OFF_LAST = CW'(OFF_CYCLES - 1);
  localparam logic [SW-1:0] SET_LAST = SW'(SETTLE_CYCLES - 1);

  typedef enum logic [1:0] {S_IDLE, S_VAL_ON, S_REG, S_VAL_OFF} st_t;

  st_t               st_q;
  logic [CW-1:0]     cnt_q;
  logic [SW-1:0]     set_q;
  logic [CODE_W-1:0] latch_q;

  wire holding = (st_q == S_REG) || (st_q == S_VAL_OFF);

  assign q_drive = oe;
  assign q_data  = oe ? latch_q : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q      <= S_IDLE;
      cnt_q     <= '0;
      set_q     <= '0;
      latch_q   <= '0;
      guard_out <= 1'b0;
      steer_dly <= 1'b0;
    end else begin
      if (holding) begin
        guard_out <= sig_det;
        if (!steer_dly) begin
          if (set_q == SET_LAST) steer_dly <= 1'b1;
          else                   set_q     <= set_q + 1'b1;
        end
      end
      case (st_q)
        S_IDLE: begin
          guard_out <= 1'b0;
          if (sig_det) begin
            st_q  <= S_VAL_ON;
            cnt_q <= CW'(1);
          end
        end
        S_VAL_ON: begin
          if (!sig_det) begin
            st_q  <= S_IDLE;
            cnt_q <= '0;
          end else if (cnt_q == ON_LAST) begin
            latch_q   <= code_in;
            guard_out <= 1'b1;
            st_q      <= S_REG;
            cnt_q     <= '0;
            set_q     <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        S_REG: begin
          if (!sig_det) begin
            st_q  <= S_VAL_OFF;
            cnt_q <= CW'(1);
          end
        end
        default: begin
          if (sig_det) begin
            st_q  <= S_REG;
            cnt_q <= '0;
          end else if (cnt_q >= OFF_LAST) begin
            if (steer_dly) begin
              st_q      <= S_IDLE;
              steer_dly <= 1'b0;
              guard_out <= 1'b0;
              cnt_q     <= '0;
            end
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
      endcase
    end
  end
endmodule

module dtmf_steer_chk #(parameter int W = 4) (
  input logic         clk,
  input logic         rst_n,
  input logic         sig_det,
  input logic         oe,
  input logic         guard_out,
  input logic         steer_dly,
  input logic [W-1:0] q_data,
  input logic [W-1:0] held
);
  a_r2_load_with_guard: assert property (@(posedge clk) disable iff (!rst_n)
    (oe && $past(oe) && q_data != $past(q_data)) |-> $rose(guard_out));
  a_r4_guard_needs_tone: assert property (@(posedge clk) disable iff (!rst_n)
    guard_out |-> $past(sig_det));
  a_r6_clear_after_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(steer_dly) |-> (!$past(sig_det) && !guard_out));
  a_r7_latch_held: assert property (@(posedge clk) disable iff (!rst_n)
    (steer_dly && $past(steer_dly)) |-> $stable(held));
  a_r5_flag_after_load: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(steer_dly) |-> $stable(held));
endmodule

bind dtmf_steer dtmf_steer_chk #(.W(CODE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sig_det(sig_det), .oe(oe),
  .guard_out(guard_out), .steer_dly(steer_dly), .q_data(q_data), .held(latch_q));

// File: tb/test_dtmf_steer.sv
module test_dtmf_steer;
  localparam int ON = 5, OFF = 4, SET = 2;
  logic clk = 0, rst_n = 0, sig_det = 0, oe = 0;
  logic [3:0] code_in = 0;
  logic [3:0] q_data;
  logic q_drive, guard_out, steer_dly;
  int total = 0, bad = 0;
  logic [3:0] exp_latch = 0;

  always #2.5 clk = ~clk;

  dtmf_steer #(.CODE_W(4), .ON_CYCLES(ON), .OFF_CYCLES(OFF), .SETTLE_CYCLES(SET)) i_dtmf_steer (
    .clk(clk), .rst_n(rst_n), .sig_det(sig_det), .code_in(code_in), .oe(oe),
    .q_data(q_data), .q_drive(q_drive), .guard_out(guard_out), .steer_dly(steer_dly));

  task automatic chk(input int act, input int exp, input string tag);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic hold(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #1_000_000;
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    hold(3);
    rst_n = 1;
    hold(1);
    chk(q_drive, 0, "R8 released drive");
    chk(q_data, 0, "R8 released data");
    oe = 1;
    hold(1);
    chk(q_data, 0, "R1 latch");
    chk(guard_out, 0, "R1 guard");
    chk(steer_dly, 0, "R1 steer");
    chk(q_drive, 1, "R8 driven");

    for (int c = 0; c < 16; c++) begin
      for (int len = 1; len <= ON + 1; len++) begin
        logic [3:0] code;
        code = 4'((c * 5 + len * 3) & 15);
        code_in = code;
        sig_det = 1;
        if (len == ON) begin
          hold(ON - 1);
          chk(guard_out, 0, "R2 guard before period");
          hold(1);
          chk(guard_out, 1, "R2 guard at period");
          chk(q_data, code, "R2 latch load");
          chk(steer_dly, 0, "R5 steer not yet");
          hold(SET - 1);
          chk(steer_dly, 0, "R5 steer one early");
          hold(1);
          chk(steer_dly, 1, "R5 steer on time");
          exp_latch = code;
        end else begin
          hold(len);
          if (len > ON) exp_latch = code;
          chk(guard_out, len >= ON, "R3 guard after burst");
          chk(q_data, exp_latch, "R3 latch after burst");
        end
        sig_det = 0;
        hold(1);
        if (len >= ON) chk(guard_out, 0, "R4 guard follows tone");
        hold(OFF + SET + 2);
        chk(steer_dly, 0, "R6 released");
        chk(q_data, exp_latch, "R3 latch kept");
      end
    end

    code_in = 4'd9; sig_det = 1; hold(ON + SET + 1);
    exp_latch = 4'd9;
    chk(q_data, 9, "R2 digit nine");
    for (int d = 1; d < OFF; d++) begin
      sig_det = 0; code_in = 4'(d);
      hold(d);
      chk(steer_dly, 1, "R6 dropout tolerated");
      chk(guard_out, 0, "R4 guard low in dropout");
      sig_det = 1;
      hold(1);
      chk(guard_out, 1, "R4 guard back");
      chk(q_data, 9, "R7 latch held over dropout");
      hold(ON + 1);
      chk(q_data, 9, "R7 no new code while held");
    end
    oe = 0;
    hold(1);
    chk(q_drive, 0, "R8 drive off");
    chk(q_data, 0, "R8 data off");
    oe = 1;
    sig_det = 0;
    hold(OFF - 1);
    chk(steer_dly, 1, "R6 before pause end");
    hold(1);
    chk(steer_dly, 0, "R6 at pause end");
    code_in = 4'd6; sig_det = 1; hold(ON);
    chk(q_data, 6, "R7 new code after clear");
    sig_det = 0; hold(OFF + 2);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule